// File: doc/BRIEF.md
# First-Fit Contiguous Page Allocator

This block keeps the occupancy map of a 128-page scratch memory, where each page holds sixteen 32-bit words. Each hardware queue is given one run of contiguous pages. A client sends an allocate request with a queue number, a length in words and two watermark values. The block checks the arguments and checks whether the queue already holds a run. It then searches for space and returns the base page of the run it has claimed. A release request gives the base page and size code of a run, and the block hands those pages back.

The search is first-fit and ignores alignment. A candidate run starts at page 0. On each clock cycle the block tests one candidate against the occupancy map. If the candidate overlaps a page in use, the run mask moves up by one page. The search fails when the next candidate would run past the search window. The four lowest pages hold configuration data. They are busy from reset onward and no release can ever free them.

Requests use a valid/ready handshake. Each request ends with a one-cycle done strobe that carries a status code and a base page.

Top module: `page_alloc`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_done` is 0. Pages 0 to 3 count as occupied, so the first one-page allocation after reset returns base 4.
- R2: The word counts 16, 32, 64 and 128 request runs of 1, 2, 4 and 8 pages (size codes 0 to 3). Any other word count, 0 included, completes with status 1 (argument error) and base 0.
- R3: A value above 7 in either watermark field gives status 1. A value of 7 is accepted. An argument error takes precedence over the busy check.
- R4: An allocation for a queue that already owns a run completes with status 2 (busy) and changes nothing. A release clears the ownership of its queue. A failed search does not give the queue ownership.
- R5: A successful allocation returns status 0 and the lowest base page whose whole run overlaps no occupied page. The base need not be aligned to the run size.
- R6: A search tests one candidate per clock. A success at base b raises `rsp_done` on the (b+1)-th rising edge after the acceptance edge. Releases and rejected requests raise it on the acceptance edge itself.
- R7: If the next candidate base plus the run length would exceed the 128-page window, the request completes with status 3 (out of space) and base 0.
- R8: A release completes with status 0 and echoes its base. It frees every page of the run except pages 0 to 3, which stay occupied.
- R9: `req_ready` is low from the acceptance edge until the result appears. `rsp_done` is high for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_free | input | 1 | 1 = release, 0 = allocate |
| req_queue | input | 6 | Queue number |
| req_words | input | 8 | Allocation length in words |
| req_wm_lo | input | 4 | Low watermark value (legal 0 to 7) |
| req_wm_hi | input | 4 | High watermark value (legal 0 to 7) |
| req_base | input | 8 | Base page of the run to release |
| req_size | input | 2 | Size code of the run to release |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 0 ok, 1 argument error, 2 busy, 3 out of space |
| rsp_base | output | 8 | Base page of the claimed or released run |

## Verification
The bench first opens holes in the map and then refills them. A design that searched only aligned bases would put a two-page run at 6 rather than 5, and one that skipped holes would miss the one-page gap at 6. It fills the window to the last page. An off-by-one in the out-of-space test would then either reject the final legal run at page 127 or claim a run beyond the end. It releases a run that covers the reserved pages and expects the next one-page allocation to land on page 4, not page 0. It measures the latency of every result, so a design that tested more or fewer than one candidate per clock, or that delayed a rejection, would produce the wrong edge count.

// File: rtl/qalloc_pkg.sv
package qalloc_pkg;

    typedef enum logic [1:0] {
        QA_OK      = 2'd0,
        QA_BADARG  = 2'd1,
        QA_BUSY    = 2'd2,
        QA_NOSPACE = 2'd3
    } qa_status_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } qa_phase_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] code;
    } qa_len_t;

    // Turn a word count into a size code; only four power-of-two lengths are legal.
    function automatic qa_len_t decode_len(input int words);
        qa_len_t r;
        r.ok   = 1'b1;
        r.code = 2'd0;
        case (words)
            16:      r.code = 2'd0;
            32:      r.code = 2'd1;
            64:      r.code = 2'd2;
            128:     r.code = 2'd3;
            default: r.ok   = 1'b0;
        endcase
        return r;
    endfunction

    function automatic int run_pages(input logic [1:0] code);
        return 1 << code;
    endfunction

endpackage

// File: rtl/qa_req_check.sv
module qa_req_check
    import qalloc_pkg::*;
#(
    parameter int WORDS_W = 8,
    parameter int WM_W    = 4,
    parameter int WM_MAX  = 7
) (
    input  logic [WORDS_W-1:0] words,
    input  logic [WM_W-1:0]    wm_lo,
    input  logic [WM_W-1:0]    wm_hi,
    output logic               args_ok,
    output logic [1:0]         size_code
);
    qa_len_t len;

    always_comb begin
        len       = decode_len(int'(words));
        size_code = len.code;
        args_ok   = len.ok && (int'(wm_lo) <= WM_MAX) && (int'(wm_hi) <= WM_MAX);
    end
endmodule

// File: rtl/qa_run_mask.sv
module qa_run_mask
    import qalloc_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int BASE_W    = 8
) (
    input  logic [1:0]           size_code,
    input  logic [BASE_W-1:0]    base,
    output logic [NUM_PAGES-1:0] mask
);
    int npages;
    assign npages = run_pages(size_code);

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        assign mask[p] = (p >= int'(base)) && (p < int'(base) + npages);
    end
endmodule

// File: rtl/page_alloc.sv
module page_alloc
    import qalloc_pkg::*;
#(
    parameter int NUM_PAGES    = 128,
    parameter int RESV_PAGES   = 4,
    parameter int SEARCH_LIMIT = 128,
    parameter int NUM_QUEUES   = 64,
    parameter int QID_W        = $clog2(NUM_QUEUES),
    parameter int BASE_W       = 8,
    parameter int WORDS_W      = 8,
    parameter int WM_W         = 4,
    parameter int WM_MAX       = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_free,
    input  logic [QID_W-1:0]   req_queue,
    input  logic [WORDS_W-1:0] req_words,
    input  logic [WM_W-1:0]    req_wm_lo,
    input  logic [WM_W-1:0]    req_wm_hi,
    input  logic [BASE_W-1:0]  req_base,
    input  logic [1:0]         req_size,
    output logic               rsp_done,
    output logic [1:0]         rsp_status,
    output logic [BASE_W-1:0]  rsp_base
);
    localparam logic [NUM_PAGES-1:0] RESV_MASK =
        {{(NUM_PAGES-RESV_PAGES){1'b0}}, {RESV_PAGES{1'b1}}};

    qa_phase_e            phase;
    logic [NUM_PAGES-1:0] used;
    logic [NUM_QUEUES-1:0] owned;
    logic [BASE_W-1:0]    cand;
    logic [NUM_PAGES-1:0] cur_mask;
    logic [1:0]           cur_code;
    logic [QID_W-1:0]     cur_q;
    logic                 cur_alloc;
    logic                 done_q;
    qa_status_e           status_q;
    logic [BASE_W-1:0]    base_q;

    logic                 chk_ok;
    logic [1:0]           chk_code;
    logic [1:0]           gen_code;
    logic [BASE_W-1:0]    gen_base;
    logic [NUM_PAGES-1:0] gen_mask;
    logic                 hit;
    logic                 past_end;

    qa_req_check #(
        .WORDS_W (WORDS_W),
        .WM_W    (WM_W),
        .WM_MAX  (WM_MAX)
    ) u_check (
        .words     (req_words),
        .wm_lo     (req_wm_lo),
        .wm_hi     (req_wm_hi),
        .args_ok   (chk_ok),
        .size_code (chk_code)
    );

    // One generator serves both paths: base 0 seeds a search, the request base builds a release.
    assign gen_code = req_free ? req_size : chk_code;
    assign gen_base = req_free ? req_base : '0;

    qa_run_mask #(
        .NUM_PAGES (NUM_PAGES),
        .BASE_W    (BASE_W)
    ) u_mask (
        .size_code (gen_code),
        .base      (gen_base),
        .mask      (gen_mask)
    );

    assign hit      = ~|(used & cur_mask);
    assign past_end = (int'(cand) + 1 + run_pages(cur_code)) > SEARCH_LIMIT;

    assign req_ready  = (phase == PH_IDLE);
    assign rsp_done   = done_q;
    assign rsp_status = status_q;
    assign rsp_base   = base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            used      <= RESV_MASK;
            owned     <= '0;
            cand      <= '0;
            cur_mask  <= '0;
            cur_code  <= 2'd0;
            cur_q     <= '0;
            cur_alloc <= 1'b0;
            done_q    <= 1'b0;
            status_q  <= QA_OK;
            base_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_q     <= req_queue;
                        cur_alloc <= !req_free;
                        cur_code  <= gen_code;
                        if (req_free) begin
                            used             <= (used & ~gen_mask) | RESV_MASK;
                            owned[req_queue] <= 1'b0;
                            done_q           <= 1'b1;
                            status_q         <= QA_OK;
                            base_q           <= req_base;
                        end else if (!chk_ok) begin
                            done_q   <= 1'b1;
                            status_q <= QA_BADARG;
                            base_q   <= '0;
                        end else if (owned[req_queue]) begin
                            done_q   <= 1'b1;
                            status_q <= QA_BUSY;
                            base_q   <= '0;
                        end else begin
                            phase    <= PH_SCAN;
                            cand     <= '0;
                            cur_mask <= gen_mask;
                        end
                    end
                end
                PH_SCAN: begin
                    if (hit) begin
                        used         <= used | cur_mask;
                        owned[cur_q] <= 1'b1;
                        done_q       <= 1'b1;
                        status_q     <= QA_OK;
                        base_q       <= cand;
                        phase        <= PH_IDLE;
                    end else if (past_end) begin
                        done_q   <= 1'b1;
                        status_q <= QA_NOSPACE;
                        base_q   <= '0;
                        phase    <= PH_IDLE;
                    end else begin
                        cand     <= cand + BASE_W'(1);
                        cur_mask <= cur_mask << 1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R1: configuration pages never become free
    a_r1_reserved_held: assert property (@(posedge clk) disable iff (rst)
        &used[RESV_PAGES-1:0]);

    // R6: consecutive scan cycles advance exactly one page
    a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SCAN && $past(phase == PH_SCAN)) |-> cand == $past(cand) + BASE_W'(1));

    // R5: a free candidate is claimed in the occupancy map
    a_r5_claim_marks: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SCAN && hit) |=> (used & $past(cur_mask)) == $past(cur_mask));

    // R7: a granted run lies above the reserved pages and inside the window
    a_r7_base_in_window: assert property (@(posedge clk) disable iff (rst)
        (done_q && status_q == QA_OK && cur_alloc) |->
            (int'(base_q) >= RESV_PAGES &&
             int'(base_q) + run_pages(cur_code) <= SEARCH_LIMIT));
endmodule

// File: tb/page_alloc_bench.sv
module page_alloc_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_ready, req_free;
    logic [5:0] req_queue;
    logic [7:0] req_words;
    logic [3:0] req_wm_lo, req_wm_hi;
    logic [7:0] req_base;
    logic [1:0] req_size;
    logic       rsp_done;
    logic [1:0] rsp_status;
    logic [7:0] rsp_base;

    int checks = 0;
    int fails  = 0;
    int lat;
    bit ready_held_low;
    bit hung = 1'b0;
    logic [1:0] got_st;
    logic [7:0] got_base;

    always #10 clk = ~clk;

    page_alloc u_page_alloc (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_free(req_free), .req_queue(req_queue), .req_words(req_words),
        .req_wm_lo(req_wm_lo), .req_wm_hi(req_wm_hi), .req_base(req_base),
        .req_size(req_size), .rsp_done(rsp_done), .rsp_status(rsp_status),
        .rsp_base(rsp_base)
    );

    typedef struct packed {
        logic       fr;
        logic [5:0] q;
        logic [7:0] words;
        logic [3:0] wl;
        logic [3:0] wh;
        logic [7:0] base;
        logic [1:0] sz;
        logic [1:0] est;
        logic [7:0] ebase;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 6'd0,  8'd16,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd4},   // R1 R5
        '{1'b0, 6'd1,  8'd32,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd5},   // R5 unaligned
        '{1'b0, 6'd2,  8'd64,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd7},   // R2
        '{1'b0, 6'd0,  8'd16,  4'd0, 4'd0, 8'd0, 2'd0, 2'd2, 8'd0},   // R4 busy
        '{1'b0, 6'd3,  8'd48,  4'd0, 4'd0, 8'd0, 2'd0, 2'd1, 8'd0},   // R2 bad len
        '{1'b0, 6'd3,  8'd16,  4'd8, 4'd0, 8'd0, 2'd0, 2'd1, 8'd0},   // R3 wm lo
        '{1'b0, 6'd3,  8'd128, 4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd11},  // R2 eight pages
        '{1'b1, 6'd1,  8'd0,   4'd0, 4'd0, 8'd5, 2'd1, 2'd0, 8'd5},   // R8 release
        '{1'b0, 6'd4,  8'd16,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd5},   // R5 hole
        '{1'b0, 6'd5,  8'd32,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd19},  // R5 skip small hole
        '{1'b0, 6'd6,  8'd16,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd6},   // R5 fill hole
        '{1'b0, 6'd0,  8'd16,  4'd0, 4'd9, 8'd0, 2'd0, 2'd1, 8'd0},   // R3 precedence
        '{1'b0, 6'd1,  8'd16,  4'd0, 4'd0, 8'd0, 2'd0, 2'd0, 8'd21},  // R4 reuse
        '{1'b0, 6'd7,  8'd0,   4'd0, 4'd0, 8'd0, 2'd0, 2'd1, 8'd0},   // R2 zero len
        '{1'b0, 6'd7,  8'd16,  4'd7, 4'd7, 8'd0, 2'd0, 2'd0, 8'd22}   // R3 wm 7 ok
    };

    task automatic issue(input logic fr, input logic [5:0] q, input logic [7:0] w,
                         input logic [3:0] wl, input logic [3:0] wh,
                         input logic [7:0] b, input logic [1:0] sz);
        @(negedge clk);
        req_free = fr; req_queue = q; req_words = w;
        req_wm_lo = wl; req_wm_hi = wh; req_base = b; req_size = sz;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        ready_held_low = 1'b1;
        while (!rsp_done && lat < 400) begin
            if (req_ready) ready_held_low = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (!rsp_done) hung = 1'b1;
        got_st = rsp_status;
        got_base = rsp_base;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_res(input string req, input logic [1:0] st, input logic [7:0] b);
        check(got_st == st, {req, " status"}, int'(got_st), int'(st));
        check(got_base == b, {req, " base"}, int'(got_base), int'(b));
    endtask

    initial begin
        req_valid = 1'b0; req_free = 1'b0; req_queue = '0; req_words = '0;
        req_wm_lo = '0; req_wm_hi = '0; req_base = '0; req_size = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(rsp_done == 1'b0, "R1 done after reset", int'(rsp_done), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int elat;
            v = TABLE[i];
            issue(v.fr, v.q, v.words, v.wl, v.wh, v.base, v.sz);
            expect_res($sformatf("R5 row %0d", i), v.est, v.ebase);
            elat = (v.est == 2'd0 && !v.fr) ? int'(v.ebase) + 1 : 0;
            check(lat == elat, $sformatf("R6 latency row %0d", i), lat, elat);
            if (elat > 0)
                check(ready_held_low, $sformatf("R9 ready low row %0d", i), 0, 1);
            @(negedge clk);
            check(rsp_done == 1'b0, $sformatf("R9 done strobe row %0d", i), int'(rsp_done), 0);
        end

        // Fill the window with eight-page runs from page 23
        for (int k = 0; k < 13; k++) begin
            issue(1'b0, 6'(8 + k), 8'd128, 4'd0, 4'd0, 8'd0, 2'd0);
            expect_res("R5 fill", 2'd0, 8'(23 + 8 * k));
        end
        issue(1'b0, 6'd21, 8'd128, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R7 eight pages no room", 2'd3, 8'd0);
        issue(1'b0, 6'd22, 8'd32, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R7 two pages no room", 2'd3, 8'd0);
        issue(1'b0, 6'd23, 8'd16, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R7 last page fits", 2'd0, 8'd127);
        check(lat == 128, "R6 latency base 127", lat, 128);
        issue(1'b0, 6'd24, 8'd16, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R7 full", 2'd3, 8'd0);
        check(lat == 128, "R7 latency full scan", lat, 128);

        // Release over the reserved pages
        issue(1'b1, 6'd63, 8'd0, 4'd0, 4'd0, 8'd0, 2'd3);
        expect_res("R8 release reserved span", 2'd0, 8'd0);
        check(lat == 0, "R6 release latency", lat, 0);
        issue(1'b0, 6'd21, 8'd16, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R8 R4 reserved kept, queue not owned", 2'd0, 8'd4);
        check(lat == 5, "R6 latency base 4", lat, 5);
        issue(1'b0, 6'd25, 8'd64, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R7 four pages no room", 2'd3, 8'd0);
        issue(1'b0, 6'd26, 8'd32, 4'd0, 4'd0, 8'd0, 2'd0);
        expect_res("R8 freed pages reused", 2'd0, 8'd5);

        check(!hung, "R9 response arrived", int'(hung), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL R9 watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule